// File: doc/BRIEF.md
# USB Endpoint Receive FIFO

This block is a byte-wide circular buffer that sits behind one USB OUT endpoint. The endpoint controller pushes received packet bytes into it. Software pops them from the other side at its own pace. Because both sides work at once, a packet longer than the buffer can stream through, as long as software keeps draining it.

The block holds a write pointer and a read pointer, both wrapping at the configured depth. An occupancy counter tells an empty buffer apart from a full one. The block reports:
- how many bytes can be read;
- how much room is left;
- a sticky low-space warning against a programmable threshold.

A write into a full buffer is dropped and flags a sticky overrun. A read from an empty buffer does not advance the read pointer and presents the last byte again. A flush returns the buffer to empty and has priority over everything else.

Top module: `ep_rx_fifo`

## Requirements
- R1: Each write accepted while the buffer is not full stores `wr_data` and advances the write pointer, which wraps from DEPTH-1 to 0 (DEPTH need not be a power of two). Bytes come out in the order they were written, across the wrap.
- R2: A read strobe while the buffer holds data presents the oldest byte on `rd_data` in the cycle after the strobe, and lowers `rd_count` by one.
- R3: A read strobe while the buffer is empty leaves `rd_data` at the last byte read, and leaves `rd_count` at 0.
- R4: A write strobe while the buffer is full drops the byte, leaves the stored contents and the count unchanged, and sets `overrun` in the next cycle.
- R5: `rd_count` equals the number of bytes held (0 to DEPTH). `empty` is 1 exactly when it is 0, and `full` is 1 exactly when it is DEPTH.
- R6: `free_level` always equals DEPTH minus `rd_count`.
- R7: `warn` is 1 in the cycle after any cycle whose resulting free level is at or below `warn_thresh`. It then stays set until a `clr_flags` cycle in which the condition no longer holds, or until a flush.
- R8: `flush` sets both pointers and the count to zero and clears `overrun` and `warn`. It overrides any read or write in the same cycle, and leaves `rd_data` unchanged.
- R9: A read and a write in the same cycle, while the buffer is neither empty nor full, are both accepted and `rd_count` stays the same.
- R10: `clr_flags` clears `overrun`, except in a cycle that itself overruns, in which case `overrun` stays set.
- R11: After reset, `rd_count` is 0, `free_level` is DEPTH, `empty` is 1, `full`, `overrun` and `warn` are 0, and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Endpoint-side write strobe |
| wr_data | input | WIDTH | Byte to store |
| rd_en | input | 1 | Software read strobe |
| rd_data | output | WIDTH | Byte delivered by the latest accepted read |
| warn_thresh | input | CNT_W | Free-space warning threshold |
| flush | input | 1 | Empty the buffer and clear flags |
| clr_flags | input | 1 | Clear the sticky overrun and warning flags |
| rd_count | output | CNT_W | Bytes available to read |
| free_level | output | CNT_W | Bytes that can still be written |
| empty | output | 1 | Buffer holds no data |
| full | output | 1 | Buffer has no free space |
| overrun | output | 1 | Sticky: a write hit a full buffer |
| warn | output | 1 | Sticky: free space at or below threshold |

## Verification
The assertions assume that `warn_thresh` is held steady except in idle cycles. This keeps the warning property meaningful. They also assume that strobes are single-cycle pulses sampled on the rising edge, with `clr_flags` and `flush` never relied on to mask each other. The stimulus drives every input half a cycle before the active edge. It changes the threshold only while the buffer is idle, and it makes every overrun, underrun and flush a deliberate, isolated row whose expected state was worked out by hand for a depth-6 buffer. That depth forces the write pointer through a wrap that is not a power-of-two boundary.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Sticky condition flags kept by the controller.
    typedef struct packed {
        logic ovr;
        logic warn;
    } rxq_flags_t;

    // Pointer width that stays legal for a one-entry buffer.
    function automatic int ptr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/rxq_wrap_ctr.sv
module rxq_wrap_ctr #(
    parameter int DEPTH = 16,
    parameter int PTR_W = rxq_pkg::ptr_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam bit POW2 = ((1 << PTR_W) == DEPTH);

    logic [PTR_W-1:0] ptr_d, ptr_q, inc;

    generate
        if (POW2) begin : g_pow2
            // Natural roll-over of the counter is the wrap.
            always_comb inc = ptr_q + 1'b1;
        end else begin : g_cmp
            always_comb inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    endgenerate

    always_comb begin
        ptr_d = ptr_q;
        if (clr)       ptr_d = '0;
        else if (step) ptr_d = inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    p_ptr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr_q) < DEPTH)
        else $error("pointer left range");

    p_ptr_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && ptr_q == LAST) |=> (ptr_q == '0))
        else $error("pointer did not wrap");

endmodule

// File: rtl/rxq_mem.sv
module rxq_mem #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter int PTR_W = rxq_pkg::ptr_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    // Storage carries no reset; contents are only visible after a write.
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/ep_rx_fifo.sv
module ep_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic [CNT_W-1:0] warn_thresh,
    input  logic             flush,
    input  logic             clr_flags,
    output logic [CNT_W-1:0] rd_count,
    output logic [CNT_W-1:0] free_level,
    output logic             empty,
    output logic             full,
    output logic             overrun,
    output logic             warn
);

    import rxq_pkg::*;

    localparam int PTR_W = ptr_bits(DEPTH);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        rxq_flags_t       flg;
        logic [WIDTH-1:0] rdat;
    } state_t;

    state_t st_d, st_q;

    logic             wr_ok, rd_ok;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [WIDTH-1:0] mem_rdata;
    logic [CNT_W-1:0] lvl_nxt;

    rxq_wrap_ctr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_wptr (
        .clk(clk), .rst_n(rst_n), .clr(flush), .step(wr_ok), .ptr(wr_ptr)
    );

    rxq_wrap_ctr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_rptr (
        .clk(clk), .rst_n(rst_n), .clr(flush), .step(rd_ok), .ptr(rd_ptr)
    );

    rxq_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W)) u_mem (
        .clk(clk), .we(wr_ok), .waddr(wr_ptr), .wdata(wr_data),
        .raddr(rd_ptr), .rdata(mem_rdata)
    );

    assign empty      = (st_q.cnt == '0);
    assign full       = (st_q.cnt == DEPTH_C);
    assign wr_ok      = wr_en && !full  && !flush;
    assign rd_ok      = rd_en && !empty && !flush;

    always_comb begin
        st_d    = st_q;
        lvl_nxt = DEPTH_C;
        if (flush) begin
            st_d.cnt      = '0;
            st_d.flg.ovr  = 1'b0;
            st_d.flg.warn = 1'b0;
        end else begin
            unique case ({wr_ok, rd_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
            if (rd_ok) st_d.rdat = mem_rdata;
            // A fresh overrun outranks the clear strobe.
            st_d.flg.ovr  = (wr_en && full) || (st_q.flg.ovr && !clr_flags);
            lvl_nxt       = DEPTH_C - st_d.cnt;
            st_d.flg.warn = (lvl_nxt <= warn_thresh) ||
                            (st_q.flg.warn && !clr_flags);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data    = st_q.rdat;
    assign rd_count   = st_q.cnt;
    assign free_level = DEPTH_C - st_q.cnt;
    assign overrun    = st_q.flg.ovr;
    assign warn       = st_q.flg.warn;

    p_cnt_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(wr_ptr) + DEPTH - int'(rd_ptr)) % DEPTH) == (int'(st_q.cnt) % DEPTH))
        else $error("count disagrees with pointers");

    p_underrun_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en && !flush) |=> ($stable(rd_data) && empty))
        else $error("underrun changed read data");

    p_overrun_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en && !flush) |=> (full && overrun))
        else $error("overrun not flagged");

    p_warn_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && lvl_nxt <= warn_thresh) |=> warn)
        else $error("warning missed");

    p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !overrun && !warn))
        else $error("flush incomplete");

    p_simul_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && !empty && !full && !flush) |=> $stable(rd_count))
        else $error("count moved on read+write");

    p_ovr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flags && !flush && !(wr_en && full)) |=> !overrun)
        else $error("overrun not cleared");

endmodule

// File: tb/ep_rx_fifo_test.sv
module ep_rx_fifo_test;

    localparam int D  = 6;
    localparam int CW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0, flush = 1'b0, clr_flags = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [CW-1:0] warn_thresh = CW'(1);
    logic [7:0]    rd_data;
    logic [CW-1:0] rd_count, free_level;
    logic          empty, full, overrun, warn;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ep_rx_fifo #(.DEPTH(D), .WIDTH(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .warn_thresh(warn_thresh),
        .flush(flush), .clr_flags(clr_flags), .rd_count(rd_count),
        .free_level(free_level), .empty(empty), .full(full),
        .overrun(overrun), .warn(warn)
    );

    typedef struct packed {
        logic       fl, cl, wr, rd;
        logic [7:0] wd;
        logic [2:0] cnt;
        logic       ovr, wrn, chk;
        logic [7:0] rdat;
    } vec_t;

    // Threshold 1, depth 6: warning once five or more bytes are held.
    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b1,1'b0,8'h11,3'd1,1'b0,1'b0,1'b0,8'h00}, // R1
        '{1'b0,1'b0,1'b1,1'b0,8'h22,3'd2,1'b0,1'b0,1'b0,8'h00},
        '{1'b0,1'b0,1'b0,1'b1,8'h00,3'd1,1'b0,1'b0,1'b1,8'h11}, // R2
        '{1'b0,1'b0,1'b1,1'b1,8'h33,3'd1,1'b0,1'b0,1'b1,8'h22}, // R9
        '{1'b0,1'b0,1'b1,1'b0,8'h44,3'd2,1'b0,1'b0,1'b0,8'h00},
        '{1'b0,1'b0,1'b1,1'b0,8'h55,3'd3,1'b0,1'b0,1'b0,8'h00},
        '{1'b0,1'b0,1'b1,1'b0,8'h66,3'd4,1'b0,1'b0,1'b0,8'h00},
        '{1'b0,1'b0,1'b1,1'b0,8'h77,3'd5,1'b0,1'b1,1'b0,8'h00}, // R7, R1 wrap
        '{1'b0,1'b0,1'b1,1'b0,8'h88,3'd6,1'b0,1'b1,1'b0,8'h00}, // full
        '{1'b0,1'b0,1'b1,1'b0,8'h99,3'd6,1'b1,1'b1,1'b0,8'h00}, // R4
        '{1'b0,1'b1,1'b1,1'b0,8'h9A,3'd6,1'b1,1'b1,1'b0,8'h00}, // R10
        '{1'b0,1'b1,1'b0,1'b0,8'h00,3'd6,1'b0,1'b1,1'b0,8'h00}, // R10, R7
        '{1'b0,1'b0,1'b0,1'b1,8'h00,3'd5,1'b0,1'b1,1'b1,8'h33},
        '{1'b0,1'b0,1'b0,1'b1,8'h00,3'd4,1'b0,1'b1,1'b1,8'h44}, // R7 sticky
        '{1'b0,1'b1,1'b0,1'b0,8'h00,3'd4,1'b0,1'b0,1'b0,8'h00}, // R7 clear
        '{1'b0,1'b0,1'b0,1'b1,8'h00,3'd3,1'b0,1'b0,1'b1,8'h55},
        '{1'b0,1'b0,1'b0,1'b1,8'h00,3'd2,1'b0,1'b0,1'b1,8'h66},
        '{1'b0,1'b0,1'b0,1'b1,8'h00,3'd1,1'b0,1'b0,1'b1,8'h77}, // R1 order
        '{1'b0,1'b0,1'b0,1'b1,8'h00,3'd0,1'b0,1'b0,1'b1,8'h88}, // R4 dropped
        '{1'b0,1'b0,1'b0,1'b1,8'h00,3'd0,1'b0,1'b0,1'b1,8'h88}, // R3
        '{1'b1,1'b0,1'b1,1'b1,8'hAA,3'd0,1'b0,1'b0,1'b1,8'h88}, // R8
        '{1'b0,1'b0,1'b1,1'b0,8'hBB,3'd1,1'b0,1'b0,1'b0,8'h00},
        '{1'b0,1'b0,1'b0,1'b1,8'h00,3'd0,1'b0,1'b0,1'b1,8'hBB}  // R8 pointers
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_state(input int cnt, input int ovr, input int wrn);
        chk("R5 rd_count", int'(rd_count), cnt);
        chk("R6 free_level", int'(free_level), D - cnt);
        chk("R5 empty", int'(empty), int'(cnt == 0));
        chk("R5 full", int'(full), int'(cnt == D));
        chk("R4 R10 overrun", int'(overrun), ovr);
        chk("R7 warn", int'(warn), wrn);
    endtask

    task automatic drive(input logic fl, cl, wr, rd, input logic [7:0] wd);
        flush = fl; clr_flags = cl; wr_en = wr; rd_en = rd; wr_data = wd;
        @(negedge clk);
        flush = 1'b0; clr_flags = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk_state(0, 0, 0);
        chk("R11 rd_data", int'(rd_data), 0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].fl, VECS[i].cl, VECS[i].wr, VECS[i].rd, VECS[i].wd);
            chk_state(int'(VECS[i].cnt), int'(VECS[i].ovr), int'(VECS[i].wrn));
            if (VECS[i].chk)
                chk("R2 R3 rd_data", int'(rd_data), int'(VECS[i].rdat));
        end

        // R8: flush after an overrun, with read and write also strobed
        for (int k = 0; k < D; k++) drive(1'b0, 1'b0, 1'b1, 1'b0, 8'(8'hC0 + k));
        drive(1'b0, 1'b0, 1'b1, 1'b0, 8'hEE);
        chk_state(D, 1, 1);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 8'hEF);
        chk_state(0, 0, 0);
        chk("R8 rd_data kept", int'(rd_data), 8'hBB);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        chk("R3 rd_data after flush", int'(rd_data), 8'hBB);

        // R7: threshold at full depth warns on an empty buffer
        warn_thresh = CW'(D);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R7 warn empty", int'(warn), 1);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R7 warn held by condition", int'(warn), 1);
        warn_thresh = '0;
        drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R7 warn cleared", int'(warn), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule